// File: doc/BRIEF.md
# Dual-Set Graphics Bank Mapper

This block turns a 13-bit pattern-table address from a video fetch unit into a physical address in graphics ROM or RAM. Software loads two sets of page registers through a small register bus. The sprite set has eight entries and the background set has four. A page-size register picks 8 KB, 4 KB, 2 KB or 1 KB pages. The way each set maps the eight 1 KB slots of the pattern space depends on that page size.

Two flags from the fetch unit choose the set used for each lookup. Sprite fetches always use the sprite set. Background fetches use the background set while rendering is on. When rendering is off, the set that was written most recently is used. Register writes are registered. The translation path is purely combinational, and its result wraps to the size of the graphics memory. That size is a power of two given by a parameter.

Top module: `gfx_bank_mapper`

## Requirements
- R1: After a synchronous active-low reset, the page size is 1 KB (code 3), every entry and the upper-bits latch are 0, and the last-written set is the sprite set. In this state any pattern address maps to its own low 10 bits.
- R2: A write to register address 0x10 loads the page-size code from data bits [1:0] (0 = 8 KB, 1 = 4 KB, 2 = 2 KB, 3 = 1 KB). It takes effect from the next cycle, and data bits [7:2] are ignored.
- R3: Writes to register addresses 0x00-0x07 load sprite-set entries 0-7, and writes to 0x08-0x0B load background-set entries 0-3. Each entry stores the 10-bit value {upper latch[1:0], data[7:0]}. The upper latch is loaded from data bits [1:0] at address 0x11, and only the value present at the time of the entry write is used.
- R4: A sprite-set entry write marks the sprite set as last written, and a background-set entry write marks the background set.
- R5: At 8 KB pages, the sprite set uses entry 7 and the background set uses entry 3. The address is entry*8192 + pattern[12:0].
- R6: At 4 KB pages, the sprite set uses entry 3 for pattern 0x0000-0x0FFF and entry 7 for 0x1000-0x1FFF. The background set uses entry 3 for both halves. The address is entry*4096 + pattern[11:0].
- R7: At 2 KB pages, the sprite set uses entry (slot OR 1), where slot = pattern[12:10]. The background set uses entry 1 for the lower half and entry 3 for the upper half. The address is entry*2048 + pattern[10:0].
- R8: At 1 KB pages, the sprite set uses entry slot and the background set uses entry (slot mod 4). The address is entry*1024 + pattern[9:0].
- R9: With the sprite-phase flag high, the sprite set is used. Otherwise, with the rendering flag high, the background set is used. Otherwise the last-written set is used.
- R10: The physical address is the computed address modulo 2^MEM_AW.
- R11: The physical address follows changes of the pattern address and the two flags within the same cycle, with no clock edge between them.
- R12: Writes to register addresses 0x0C-0x0F and 0x12-0x1F change no entry, page size, latch or last-written set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| sprite_phase | input | 1 | High during sprite pattern fetches |
| render_on | input | 1 | High while rendering is active |
| pat_addr | input | 13 | Pattern-table address from the fetch unit |
| phys_addr | output | MEM_AW | Wrapped physical graphics-memory address |

## Verification
The bench builds the block with MEM_AW = 17, a 128 KB graphics memory. This is much smaller than the 1 MB that a 10-bit entry can address at 1 KB pages, so entries above 127 at 1 KB pages and above 15 at 8 KB pages wrap, and the upper-latch bits drive visible wrapping. At this size every page-size and set combination, the latch timing and the last-written fallback can be exercised by sweeps of all eight slots and by a long stretch of random register traffic.

// File: rtl/gbm_pkg.sv
// Shared constants and types for the dual-set graphics bank mapper.
// Assumes a 13-bit pattern space split into eight 1 KB slots.
package gbm_pkg;
    localparam int PAT_AW      = 13;
    localparam int DATA_W      = 8;
    localparam int HI_W        = 2;
    localparam int ENTRY_W     = DATA_W + HI_W;
    localparam int NUM_A       = 8;
    localparam int NUM_B       = 4;
    localparam int REG_AW      = 5;
    localparam int PAGE_SH_MIN = 10;
    localparam int SLOT_W      = PAT_AW - PAGE_SH_MIN;

    localparam logic [REG_AW-1:0] RA_A_BASE = 5'h00;
    localparam logic [REG_AW-1:0] RA_B_BASE = 5'h08;
    localparam logic [REG_AW-1:0] RA_MODE   = 5'h10;
    localparam logic [REG_AW-1:0] RA_HIGH   = 5'h11;

    typedef logic [ENTRY_W-1:0] entry_t;

    typedef enum logic [1:0] {
        MODE_8K = 2'd0,
        MODE_4K = 2'd1,
        MODE_2K = 2'd2,
        MODE_1K = 2'd3
    } page_mode_e;

    typedef enum logic {
        SET_A = 1'b0,
        SET_B = 1'b1
    } bank_set_e;
endpackage

// File: rtl/gbm_regfile.sv
// Register file: holds both entry sets, the page-size code, the
// upper-bits latch and the last-written-set marker.
// Assumes one write per cycle; writes land on the next clock edge.
module gbm_regfile
    import gbm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output entry_t              ent_a [NUM_A],
    output entry_t              ent_b [NUM_B],
    output page_mode_e          mode,
    output bank_set_e           last_set
);
    localparam int A_IDX_W = $clog2(NUM_A);
    localparam int B_IDX_W = $clog2(NUM_B);

    logic [REG_AW-1:0]  a_off;
    logic [REG_AW-1:0]  b_off;
    logic               a_hit;
    logic               b_hit;
    logic [A_IDX_W-1:0] a_idx;
    logic [B_IDX_W-1:0] b_idx;
    logic [HI_W-1:0]    hi_q;

    // Decode the register address into set hits and entry indices.
    always_comb begin
        a_off = reg_addr - RA_A_BASE;
        b_off = reg_addr - RA_B_BASE;
        a_hit = reg_we && (a_off < REG_AW'(NUM_A));
        b_hit = reg_we && (b_off < REG_AW'(NUM_B));
        a_idx = a_off[A_IDX_W-1:0];
        b_idx = b_off[B_IDX_W-1:0];
    end

    // Sprite-set entries, each captured with the current upper latch.
    for (genvar i = 0; i < NUM_A; i++) begin : g_ent_a
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_a[i] <= '0;
            else if (a_hit && (a_idx == A_IDX_W'(i)))
                ent_a[i] <= {hi_q, reg_wdata};
        end
    end

    // Background-set entries, each captured with the current upper latch.
    for (genvar j = 0; j < NUM_B; j++) begin : g_ent_b
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_b[j] <= '0;
            else if (b_hit && (b_idx == B_IDX_W'(j)))
                ent_b[j] <= {hi_q, reg_wdata};
        end
    end

    // Page-size code and upper-bits latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_1K;
            hi_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == RA_MODE)
                mode <= page_mode_e'(reg_wdata[1:0]);
            if (reg_addr == RA_HIGH)
                hi_q <= reg_wdata[HI_W-1:0];
        end
    end

    // Track which set received the most recent entry write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_set <= SET_A;
        else if (a_hit)
            last_set <= SET_A;
        else if (b_hit)
            last_set <= SET_B;
    end
endmodule

// File: rtl/gbm_page_pick.sv
// Per-set page selector: picks the entry for the current slot under
// the current page size. SPRITE_SET chooses the eight-entry layout,
// otherwise the four-entry background layout. Purely combinational.
module gbm_page_pick
    import gbm_pkg::*;
#(
    parameter bit SPRITE_SET = 1'b1,
    parameter int NUM_ENT    = NUM_A
) (
    input  entry_t             ents [NUM_ENT],
    input  page_mode_e         mode,
    input  logic [SLOT_W-1:0]  slot,
    output entry_t             page
);
    localparam int LAST = NUM_ENT - 1;
    localparam int MID  = NUM_ENT / 2 - 1;

    if (SPRITE_SET) begin : g_sprite
        // Sprite layout: the last entry covers wide pages, slot-indexed at 1 KB.
        always_comb begin
            case (mode)
                MODE_8K: page = ents[LAST];
                MODE_4K: page = slot[SLOT_W-1] ? ents[LAST] : ents[MID];
                MODE_2K: page = ents[{slot[SLOT_W-1:1], 1'b1}];
                MODE_1K: page = ents[slot];
            endcase
        end
    end else begin : g_backgnd
        // Background layout: four entries reused across both pattern halves.
        always_comb begin
            case (mode)
                MODE_8K: page = ents[LAST];
                MODE_4K: page = ents[LAST];
                MODE_2K: page = slot[SLOT_W-1] ? ents[LAST] : ents[MID];
                MODE_1K: page = ents[slot[SLOT_W-2:0]];
            endcase
        end
    end
endmodule

// File: rtl/gbm_addr_form.sv
// Address former: scales the chosen page by the page size, merges the
// in-page offset and wraps to MEM_AW bits. Purely combinational.
module gbm_addr_form
    import gbm_pkg::*;
#(
    parameter int MEM_AW = 18
) (
    input  entry_t              page,
    input  page_mode_e          mode,
    input  logic [PAT_AW-1:0]   pat_addr,
    output logic [MEM_AW-1:0]   phys_addr
);
    localparam int FULL_W = ENTRY_W + PAT_AW;
    localparam int WIDE_W = (MEM_AW > FULL_W) ? MEM_AW : FULL_W;

    logic [PAT_AW-1:0] off_mask;
    logic [WIDE_W-1:0] base;
    logic [WIDE_W-1:0] offs;
    logic [WIDE_W-1:0] full;

    // Page base plus in-page offset, truncated to the memory size.
    always_comb begin
        off_mask  = {PAT_AW{1'b1}} >> mode;
        offs      = WIDE_W'(pat_addr & off_mask);
        base      = WIDE_W'(page) << (PAT_AW - int'(mode));
        full      = base | offs;
        phys_addr = full[MEM_AW-1:0];
    end
endmodule

// File: rtl/gfx_bank_mapper.sv
// Dual-set graphics bank mapper top. Picks the sprite or background
// entry set from the fetch flags (or the last-written set while idle)
// and forms a wrapped physical address. MEM_AW is log2 of memory size.
module gfx_bank_mapper
    import gbm_pkg::*;
#(
    parameter int MEM_AW = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic                sprite_phase,
    input  logic                render_on,
    input  logic [PAT_AW-1:0]   pat_addr,
    output logic [MEM_AW-1:0]   phys_addr
);
    entry_t            ent_a [NUM_A];
    entry_t            ent_b [NUM_B];
    page_mode_e        mode;
    bank_set_e         last_set;
    bank_set_e         sel_set;
    entry_t            page_a;
    entry_t            page_b;
    entry_t            page_sel;
    logic [SLOT_W-1:0] slot;

    assign slot = pat_addr[PAT_AW-1:PAGE_SH_MIN];

    gbm_regfile u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ent_a     (ent_a),
        .ent_b     (ent_b),
        .mode      (mode),
        .last_set  (last_set)
    );

    gbm_page_pick #(.SPRITE_SET(1'b1), .NUM_ENT(NUM_A)) u_pick_a (
        .ents (ent_a),
        .mode (mode),
        .slot (slot),
        .page (page_a)
    );

    gbm_page_pick #(.SPRITE_SET(1'b0), .NUM_ENT(NUM_B)) u_pick_b (
        .ents (ent_b),
        .mode (mode),
        .slot (slot),
        .page (page_b)
    );

    // Choose the set from the fetch phase, falling back to the last written.
    always_comb begin
        if (sprite_phase)
            sel_set = SET_A;
        else if (render_on)
            sel_set = SET_B;
        else
            sel_set = last_set;
        page_sel = (sel_set == SET_A) ? page_a : page_b;
    end

    gbm_addr_form #(.MEM_AW(MEM_AW)) u_addr_form (
        .page      (page_sel),
        .mode      (mode),
        .pat_addr  (pat_addr),
        .phys_addr (phys_addr)
    );
endmodule

// File: rtl/gbm_checker.sv
// Property checker for gfx_bank_mapper, bound to every instance.
module gbm_checker
    import gbm_pkg::*;
#(
    parameter int MEM_AW = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [HI_W-1:0]   wdata_lo,
    input logic              sprite_phase,
    input logic [PAT_AW-1:0] pat_addr,
    input logic [MEM_AW-1:0] phys_addr,
    input page_mode_e        mode,
    input bank_set_e         last_set,
    input entry_t            page_a,
    input entry_t            page_sel
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode == MODE_1K) && (last_set == SET_A)); // R1

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RA_MODE) |=> (mode == page_mode_e'($past(wdata_lo)))); // R2

    AST_LAST_SPRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr < 5'h08) |=> (last_set == SET_A)); // R4

    AST_LAST_BACKGND: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr >= 5'h08 && reg_addr < 5'h0C) |=> (last_set == SET_B)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(mode) && $stable(last_set)); // R12

    AST_SPRITE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        sprite_phase |-> (page_sel == page_a)); // R9

    if (MEM_AW >= PAGE_SH_MIN) begin : g_off
        AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            phys_addr[PAGE_SH_MIN-1:0] == pat_addr[PAGE_SH_MIN-1:0]); // R8
    end
endmodule

bind gfx_bank_mapper gbm_checker #(.MEM_AW(MEM_AW)) u_gbm_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .wdata_lo     (reg_wdata[1:0]),
    .sprite_phase (sprite_phase),
    .pat_addr     (pat_addr),
    .phys_addr    (phys_addr),
    .mode         (mode),
    .last_set     (last_set),
    .page_a       (page_a),
    .page_sel     (page_sel)
);

// File: tb/test_gfx_bank_mapper.sv
// Self-checking bench: a behavioural model is compared on every clock.
module test_gfx_bank_mapper;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_we;
    logic [4:0]    reg_addr;
    logic [7:0]    reg_wdata;
    logic          sprite_phase;
    logic          render_on;
    logic [12:0]   pat_addr;
    logic [AW-1:0] phys_addr;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    int m_a [8];
    int m_b [4];
    int m_mode;
    int m_hi;
    int m_last;   // 0 = sprite set, 1 = background set

    always #5 clk = ~clk;

    gfx_bank_mapper #(.MEM_AW(AW)) i_gfx_bank_mapper (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .sprite_phase (sprite_phase),
        .render_on    (render_on),
        .pat_addr     (pat_addr),
        .phys_addr    (phys_addr)
    );

    // Model state after reset (R1).
    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_a[i] = 0;
        for (int i = 0; i < 4; i++) m_b[i] = 0;
        m_mode = 3;
        m_hi   = 0;
        m_last = 0;
    endtask

    // Register write semantics (R2, R3, R4, R12).
    task automatic model_write(int addr, int data);
        if (addr < 8) begin
            m_a[addr] = m_hi * 256 + data;
            m_last = 0;
        end else if (addr < 12) begin
            m_b[addr - 8] = m_hi * 256 + data;
            m_last = 1;
        end else if (addr == 16) begin
            m_mode = data % 4;
        end else if (addr == 17) begin
            m_hi = data % 4;
        end
    endtask

    // Expected address from page-size rules, set choice and wrap (R5-R10 rules).
    function automatic int model_phys(bit spr, bit ren, int pat);
        int  psize;
        int  slot;
        int  page;
        bit  use_a;
        use_a = spr ? 1'b1 : (ren ? 1'b0 : (m_last == 0));
        psize = 8192 >> m_mode;
        slot  = pat / 1024;
        if (use_a) begin
            case (m_mode)
                0:       page = m_a[7];
                1:       page = (pat < 4096) ? m_a[3] : m_a[7];
                2:       page = m_a[slot | 1];
                default: page = m_a[slot];
            endcase
        end else begin
            case (m_mode)
                0, 1:    page = m_b[3];
                2:       page = (pat < 4096) ? m_b[1] : m_b[3];
                default: page = m_b[slot % 4];
            endcase
        end
        return (page * psize + pat % psize) % (1 << AW);
    endfunction

    task automatic check(string tag, int exp);
        checks++;
        if (phys_addr !== exp[AW-1:0]) begin
            failures++;
            $display("FAIL %s: phys_addr=%h expected=%h", tag, phys_addr, exp[AW-1:0]);
        end
    endtask

    // One clock: drive at the falling edge, compare, then apply any write.
    task automatic step(string tag, bit we, int addr, int data, bit spr, bit ren, int pat);
        @(negedge clk);
        reg_we       = we;
        reg_addr     = addr[4:0];
        reg_wdata    = data[7:0];
        sprite_phase = spr;
        render_on    = ren;
        pat_addr     = pat[12:0];
        #1 check(tag, model_phys(spr, ren, pat));
        @(posedge clk);
        if (we) model_write(addr, data);
    endtask

    task automatic wr(string tag, int addr, int data);
        step(tag, 1'b1, addr, data, 1'b0, 1'b0, 0);
    endtask

    task automatic look(string tag, bit spr, bit ren, int pat);
        step(tag, 1'b0, 0, 0, spr, ren, pat);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run still busy, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        string tag;
        rst_n        = 1'b0;
        reg_we       = 1'b1;    // write during reset must be ignored (R1)
        reg_addr     = 5'h10;
        reg_wdata    = 8'h00;
        sprite_phase = 1'b0;
        render_on    = 1'b0;
        pat_addr     = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
        rst_n  = 1'b1;

        // R1: reset state, 1 KB pages with all-zero entries.
        look("R1", 1'b0, 1'b0, 'h1ABC);
        look("R1", 1'b1, 1'b0, 'h0FFF);
        look("R1", 1'b0, 1'b1, 'h1400);

        // R3: load both sets with latch 0.
        for (int i = 0; i < 8; i++) wr("R3", i, 'h10 + i);
        for (int i = 0; i < 4; i++) wr("R3", 8 + i, 'h40 + i);

        // R8 and R9: 1 KB pages, each flag combination.
        for (int s = 0; s < 8; s++) begin
            look("R8", 1'b1, 1'b0, s * 1024 + 5);
            look("R8", 1'b0, 1'b1, s * 1024 + 'h3FF);
            look("R9", 1'b1, 1'b1, s * 1024 + 7);
        end

        // R4: idle fallback follows the last-written set.
        look("R4", 1'b0, 1'b0, 'h1C05);
        wr("R4", 2, 'h22);
        look("R4", 1'b0, 1'b0, 'h1C05);
        wr("R4", 9, 'h51);
        look("R4", 1'b0, 1'b0, 'h0805);

        // R2, R5-R7: page-size sweeps with upper bits in the mode data ignored.
        for (int m = 0; m < 4; m++) begin
            wr("R2", 16, 'hFC | m);
            case (m)
                0: tag = "R5";
                1: tag = "R6";
                2: tag = "R7";
                default: tag = "R8";
            endcase
            for (int s = 0; s < 8; s++) begin
                look(tag, 1'b1, 1'b0, s * 1024 + 'h123);
                look(tag, 1'b0, 1'b1, s * 1024 + 'h3C1);
                look(tag, 1'b0, 1'b0, s * 1024 + 'h2A0);
            end
        end

        // R3 and R10: latch captured at write time, large pages wrap.
        wr("R3", 17, 3);
        wr("R3", 5, 'hFF);
        wr("R3", 11, 'h81);
        wr("R3", 17, 0);
        wr("R2", 16, 3);
        look("R10", 1'b1, 1'b0, 5 * 1024 + 'h2F);
        look("R10", 1'b0, 1'b1, 3 * 1024 + 'h11);
        look("R3", 1'b1, 1'b0, 7 * 1024);
        wr("R2", 16, 0);
        look("R10", 1'b1, 1'b0, 'h1234);
        look("R10", 1'b0, 1'b1, 'h0ABC);

        // R12: unused register addresses change nothing.
        wr("R12", 12, 'hAA);
        wr("R12", 15, 'h55);
        wr("R12", 18, 'h01);
        wr("R12", 31, 'h02);
        look("R12", 1'b0, 1'b0, 'h1FFF);
        look("R12", 1'b1, 1'b0, 'h0001);
        look("R12", 1'b0, 1'b1, 'h1001);

        // R11: two input changes within one cycle, no clock edge between.
        @(negedge clk);
        sprite_phase = 1'b1;
        render_on    = 1'b0;
        pat_addr     = 13'h0001;
        #1 check("R11", model_phys(1'b1, 1'b0, 'h0001));
        pat_addr     = 13'h1FFF;
        sprite_phase = 1'b0;
        render_on    = 1'b1;
        #1 check("R11", model_phys(1'b0, 1'b1, 'h1FFF));

        // R10: random register traffic and fetches, compared every clock.
        for (int k = 0; k < 3000; k++) begin
            step("R10", ($urandom % 3) == 0, int'($urandom_range(0, 31)),
                 int'($urandom % 256), 1'($urandom), 1'($urandom),
                 int'($urandom % 8192));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule